// File: doc/BRIEF.md
# Programmable Trigger Gate Generator

This block turns an external trigger into a gate pulse of programmable length. The trigger input is asynchronous to the reference clock, which runs at about 119 MHz. The block first synchronises the trigger and then acts only on its rising edge. Each accepted edge opens a gate that stays high for a programmed number of reference clock cycles. The allowed range is 2048 to 4096 cycles, which is roughly 17.2 us to 34 us.

The gate drives two outputs that always carry the same waveform. One output goes to the RF amplifier and the other to a diagnostic port.

On every detected trigger edge the block also gives the host two signals. The first is a one-cycle interrupt pulse, which the host uses to keep time relative to the trigger. The second is a sticky "trigger seen" flag, which the host clears by reading it.

Top module: `trig_gate_gen`

## Requirements
- R1: A rising edge on `trig_in` is detected after a two-flop synchroniser. If `trig_in` is high at clock edge k and was low at the edge before, then `gate_amp` first reads high after clock edge k+2. A trigger held high produces only one gate, so the gate does not reopen after it closes while `trig_in` stays high.
- R2: The gate stays high for exactly the clamped width in clock cycles. The width is captured when the gate opens, and later changes to `width_cfg` do not change a gate that is already open.
- R3: A `width_cfg` value below 2048 gives a gate of 2048 cycles.
- R4: A `width_cfg` value above 4096 gives a gate of 4096 cycles. Values from 2048 to 4096 are used as they are.
- R5: `gate_amp` and `gate_diag` are identical in every cycle.
- R6: `irq_pulse` is high for exactly one clock cycle for every detected trigger edge, in the same cycle the gate opens. This includes edges that arrive while the gate is already high.
- R7: `trig_seen` is set by every detected edge and stays high until `status_rd` is sampled high. If a detected edge and `status_rd` arrive in the same cycle, the flag is set.
- R8: A trigger edge that arrives while the gate is high neither restarts nor extends the gate.
- R9: After reset, `gate_amp`, `gate_diag`, `irq_pulse` and `trig_seen` are all low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock, about 119 MHz |
| rst_n | input | 1 | Active-low reset, synchronous to clk |
| trig_in | input | 1 | Asynchronous trigger input |
| width_cfg | input | 13 | Requested gate width in clock cycles |
| status_rd | input | 1 | Host read strobe; clears `trig_seen` |
| gate_amp | output | 1 | Gate output to the amplifier |
| gate_diag | output | 1 | Diagnostic copy of the gate |
| irq_pulse | output | 1 | One-cycle pulse on each trigger edge |
| trig_seen | output | 1 | Sticky trigger-seen status flag |

## Verification
Several kinds of width are applied, and each one separates a different fault:
- Random widths across the full 13-bit range show whether widths are used directly or clamped.
- Directed widths at 2047, 2048, 2049, 4096 and 4097, plus 0 and 8191, catch off-by-one errors in the clamp and the counter.
- A trigger that drops and rises again while the gate is open, with `width_cfg` changed during the same gate, separates an ignored retrigger from a restarted or stretched gate. It also shows whether the width was latched when the gate opened.
- A trigger held high through the end of the gate separates edge detection from level detection.
- A host read that lands in the same cycle as a detected edge shows which action wins on the status flag.

// File: rtl/trig_gate_pkg.sv
package trig_gate_pkg;

   typedef enum logic {
      GATE_IDLE = 1'b0,
      GATE_OPEN = 1'b1
   } gate_state_e;

   function automatic int unsigned bound_width(input int unsigned req,
                                               input int unsigned lo,
                                               input int unsigned hi);
      if (req < lo)      return lo;
      else if (req > hi) return hi;
      else               return req;
   endfunction

endpackage

// File: rtl/tg_sync_edge.sv
module tg_sync_edge #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic rise
);
   initial begin
      if (STAGES < 2) $error("tg_sync_edge: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;
   logic              last_q;

   always_ff @(posedge clk) begin
      if (!rst_n) chain[0] <= 1'b0;
      else        chain[0] <= async_in;
   end

   generate
      for (genvar i = 1; i < STAGES; i++) begin : g_stage
         always_ff @(posedge clk) begin
            if (!rst_n) chain[i] <= 1'b0;
            else        chain[i] <= chain[i-1];
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) last_q <= 1'b0;
      else        last_q <= chain[STAGES-1];
   end

   assign rise = chain[STAGES-1] & ~last_q;

   // R1: a detected edge can never last two cycles
   p_rise_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
      rise |=> !rise);
endmodule

// File: rtl/tg_width_clamp.sv
module tg_width_clamp
   import trig_gate_pkg::*;
#(
   parameter int REQ_W   = 13,
   parameter int CNT_W   = 13,
   parameter int MIN_LEN = 2048,
   parameter int MAX_LEN = 4096
) (
   input  logic [REQ_W-1:0] req,
   output logic [CNT_W-1:0] len
);
   initial begin
      if (MIN_LEN < 1)       $error("tg_width_clamp: MIN_LEN must be positive");
      if (MIN_LEN > MAX_LEN) $error("tg_width_clamp: MIN_LEN above MAX_LEN");
   end

   generate
      if (MIN_LEN == MAX_LEN) begin : g_fixed
         assign len = CNT_W'(MAX_LEN);
      end else begin : g_range
         always_comb begin
            len = CNT_W'(bound_width(int'(unsigned'(req)),
                                     int'(MIN_LEN), int'(MAX_LEN)));
         end
      end
   endgenerate
endmodule

// File: rtl/tg_gate_counter.sv
module tg_gate_counter
   import trig_gate_pkg::*;
#(
   parameter int CNT_W   = 13,
   parameter int MIN_LEN = 2048,
   parameter int MAX_LEN = 4096
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [CNT_W-1:0] len,
   output logic             gate
);
   initial begin
      if (MAX_LEN >= (1 << CNT_W)) $error("tg_gate_counter: CNT_W too narrow");
   end

   gate_state_e      state_q;
   logic [CNT_W-1:0] remain_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q  <= GATE_IDLE;
         remain_q <= '0;
      end else begin
         case (state_q)
            GATE_IDLE: begin
               if (start) begin
                  state_q  <= GATE_OPEN;
                  remain_q <= len - CNT_W'(1);
               end
            end
            GATE_OPEN: begin
               if (remain_q == '0) state_q  <= GATE_IDLE;
               else                remain_q <= remain_q - CNT_W'(1);
            end
            default: state_q <= GATE_IDLE;
         endcase
      end
   end

   assign gate = (state_q == GATE_OPEN);

   // R1: an edge seen while idle opens the gate next cycle
   p_open_on_edge_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !gate) |=> gate);
   // R2: remaining count never exceeds the widest gate
   p_count_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
      gate |-> (int'(remain_q) <= MAX_LEN - 1));
   // R8: an open gate counts down one step per cycle whatever the trigger does
   p_no_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (gate && remain_q != '0) |=> (gate && remain_q == $past(remain_q) - CNT_W'(1)));
   // R3 / R4: a freshly opened gate holds a count inside the legal range
   p_len_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !gate) |-> (int'(len) >= MIN_LEN && int'(len) <= MAX_LEN));
endmodule

// File: rtl/trig_gate_gen.sv
module trig_gate_gen
   import trig_gate_pkg::*;
#(
   parameter int WIDTH_W     = 13,
   parameter int MIN_LEN     = 2048,
   parameter int MAX_LEN     = 4096,
   parameter int SYNC_STAGES = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               trig_in,
   input  logic [WIDTH_W-1:0] width_cfg,
   input  logic               status_rd,
   output logic               gate_amp,
   output logic               gate_diag,
   output logic               irq_pulse,
   output logic               trig_seen
);
   localparam int CNT_W = $clog2(MAX_LEN + 1);

   initial begin
      if (WIDTH_W < 1) $error("trig_gate_gen: WIDTH_W must be positive");
   end

   logic             edge_det;
   logic [CNT_W-1:0] gate_len;
   logic             gate_int;
   logic             irq_q;
   logic             seen_q;

   tg_sync_edge #(.STAGES(SYNC_STAGES)) i_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in (trig_in),
      .rise     (edge_det)
   );

   tg_width_clamp #(
      .REQ_W   (WIDTH_W),
      .CNT_W   (CNT_W),
      .MIN_LEN (MIN_LEN),
      .MAX_LEN (MAX_LEN)
   ) i_clamp (
      .req (width_cfg),
      .len (gate_len)
   );

   tg_gate_counter #(
      .CNT_W   (CNT_W),
      .MIN_LEN (MIN_LEN),
      .MAX_LEN (MAX_LEN)
   ) i_count (
      .clk   (clk),
      .rst_n (rst_n),
      .start (edge_det),
      .len   (gate_len),
      .gate  (gate_int)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         irq_q  <= 1'b0;
         seen_q <= 1'b0;
      end else begin
         irq_q <= edge_det;
         if (edge_det)       seen_q <= 1'b1;
         else if (status_rd) seen_q <= 1'b0;
      end
   end

   assign gate_amp  = gate_int;
   assign gate_diag = gate_int;
   assign irq_pulse = irq_q;
   assign trig_seen = seen_q;

   // R6: interrupt is one cycle wide
   p_irq_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
      irq_pulse |=> !irq_pulse);
   // R7: an interrupt always comes with the status flag set
   p_seen_with_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
      irq_pulse |-> trig_seen);
   // R7: the flag only drops after a host read
   p_seen_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(trig_seen) |-> $past(status_rd));
   // R6: a gate never opens without an interrupt in the same cycle
   p_open_irq_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(gate_amp) |-> irq_pulse);
endmodule

// File: tb/test_trig_gate_gen.sv
module test_trig_gate_gen;
   localparam int CLK_PERIOD = 10;
   localparam int MIN_LEN    = 2048;
   localparam int MAX_LEN    = 4096;
   localparam int WATCHDOG   = 190000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        trig_in = 1'b0;
   logic [12:0] width_cfg = '0;
   logic        status_rd = 1'b0;
   logic        gate_amp, gate_diag, irq_pulse, trig_seen;

   int n_checks = 0;
   int n_fails  = 0;
   bit finished = 0;

   trig_gate_gen i_trig_gate_gen (
      .clk       (clk),
      .rst_n     (rst_n),
      .trig_in   (trig_in),
      .width_cfg (width_cfg),
      .status_rd (status_rd),
      .gate_amp  (gate_amp),
      .gate_diag (gate_diag),
      .irq_pulse (irq_pulse),
      .trig_seen (trig_seen)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   function automatic int exp_len(input int w);
      if (w < MIN_LEN) return MIN_LEN;
      if (w > MAX_LEN) return MAX_LEN;
      return w;
   endfunction

   task automatic check(input string req, input string what, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fails++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
         $finish;
      end
   endtask

   // One trigger; measures the gate and checks latency, copies, interrupt and status.
   task automatic fire(input int w, input bit retrig, input bit hold, input bit collide);
      int len;
      int extra_irq;
      int copy_err;
      width_cfg = 13'(w);
      trig_in   = 1'b1;
      @(negedge clk);
      check("R1", "gate one cycle after edge", int'(gate_amp), 0);
      @(negedge clk);
      check("R1", "gate two cycles after edge", int'(gate_amp), 0);
      if (collide) status_rd = 1'b1;
      @(negedge clk);
      status_rd = 1'b0;
      check("R1", "gate open at third edge", int'(gate_amp), 1);
      check("R6", "irq with gate open", int'(irq_pulse), 1);
      check("R7", collide ? "set beats read" : "flag set", int'(trig_seen), 1);
      len = 1; extra_irq = 0; copy_err = 0;
      forever begin
         @(negedge clk);
         if (gate_amp != gate_diag) copy_err++;
         if (len == 1) check("R6", "irq dropped after one cycle", int'(irq_pulse), 0);
         else if (irq_pulse) extra_irq++;
         if (!hold && len == 4) trig_in = 1'b0;
         if (retrig) begin
            if (len == 50)  width_cfg = 13'(MAX_LEN);
            if (len == 200) trig_in = 1'b1;
            if (len == 210) trig_in = 1'b0;
         end
         if (!gate_amp || len > 9000) break;
         len++;
      end
      check("R2", $sformatf("gate length for width %0d", w), len, exp_len(w));
      check("R5", "gate copies equal", copy_err, 0);
      if (retrig) begin
         check("R8", "retrigger does not stretch gate", len, exp_len(w));
         check("R6", "irq on retrigger inside gate", extra_irq, 1);
      end
      if (hold) begin
         repeat (10) @(negedge clk);
         check("R1", "held trigger opens no second gate", int'(gate_amp), 0);
         trig_in = 1'b0;
      end
      repeat (4) @(negedge clk);
      check("R7", "flag still set before read", int'(trig_seen), 1);
      status_rd = 1'b1;
      @(negedge clk);
      status_rd = 1'b0;
      check("R7", "flag cleared by read", int'(trig_seen), 0);
      repeat (3) @(negedge clk);
   endtask

   initial begin
      int cyc = 0;
      while (cyc < WATCHDOG) begin
         @(posedge clk);
         cyc++;
      end
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual %0d expected below %0d cycles", cyc, WATCHDOG);
      finish_run();
   end

   initial begin
      void'($urandom(32'd5417));
      repeat (3) @(negedge clk);
      check("R9", "gate_amp in reset", int'(gate_amp), 0);
      check("R9", "gate_diag in reset", int'(gate_diag), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check("R9", "irq after reset", int'(irq_pulse), 0);
      check("R9", "status after reset", int'(trig_seen), 0);

      fire(3000, 0, 0, 0);
      fire(0,    0, 0, 0);    // R3
      fire(2047, 0, 0, 0);    // R3
      fire(2048, 0, 0, 0);    // R3 boundary
      fire(2049, 0, 0, 0);
      fire(4096, 0, 0, 0);    // R4 boundary
      fire(4097, 0, 0, 0);    // R4
      fire(8191, 0, 0, 0);    // R4
      fire(2500, 1, 0, 0);    // R8 and width latch
      fire(2100, 0, 1, 0);    // R1 held trigger
      fire(2300, 0, 0, 1);    // R7 collision
      for (int i = 0; i < 6; i++) begin
         fire(int'($urandom % 8192), 0, 0, 0);
      end
      finish_run();
   end
endmodule